// File: doc/BRIEF.md
# Burst Address Counter for a Synchronous Memory Port

This block generates the address for one port of a synchronous memory. On every rising clock edge it takes exactly one of four actions: it clears its address to zero, loads a new address from the external address bus, steps its address up by one, or keeps the address it has. The registered result drives the array decode of the port directly. Successive words can therefore be read or written without presenting a new address on each cycle.

Three active-low controls choose the action: a counter clear, an address strobe and a count enable. The priority among them is fixed. Clear wins over the strobe, and the strobe wins over the count enable. The address width is a parameter. The default of 15 bits covers the smaller array depth, and 16 bits covers the larger one. Stepping past the last location wraps back to location zero. A synchronous, active-high power-on reset forces the address to zero ahead of all three controls.

No data moves through this block, so it has no valid/ready handshake. Every pin is a plain level that is sampled on each rising edge. The block applies no back-pressure, and it expects none from the array decode.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is 1 at a rising edge, `addr_o` is zero after that edge, whatever the three controls are.
- R2: With `clr_n` = 1 and `stb_n` = 0, `addr_o` takes the value of `addr_i` at that edge.
- R3: With `clr_n` = 1, `stb_n` = 1 and `step_n` = 0, `addr_o` becomes its previous value plus one.
- R4: `step_n` = 0 has no effect while `stb_n` = 0. The loaded address appears unchanged, with no extra increment.
- R5: `step_n` = 0 has no effect while `clr_n` = 0. The address becomes zero.
- R6: `clr_n` = 0 clears `addr_o` to zero even when `stb_n` = 0 is asserted at the same edge.
- R7: A step from the all-ones address (2^AW-1) gives zero.
- R8: With `clr_n`, `stb_n` and `step_n` all 1, `addr_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| clr_n | input | 1 | Counter clear, active low, highest control priority |
| stb_n | input | 1 | Address strobe, active low, loads `addr_i` |
| step_n | input | 1 | Count enable, active low, advances by one |
| addr_i | input | AW | Externally supplied address |
| addr_o | output | AW | Registered address to the array decode |

## Verification
Every result appears at `addr_o` exactly one rising edge after the controls are sampled. The path contains only one register, so clear, load, step, hold and reset all share a latency of one cycle. The bench changes its inputs on the falling edge and samples `addr_o` a short delay after the next rising edge. At that point it compares `addr_o` with a behavioural model that has applied the same control triple. The corner cases covered are the combined controls, a wrap from all ones, and a strobe with step asserted.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_CLR  = 2'd3
  } ctr_act_e;
endpackage

// File: rtl/burst_ctr_decode.sv
module burst_ctr_decode
  import burst_ctr_pkg::*;
(
  input  logic     clr_n,
  input  logic     stb_n,
  input  logic     step_n,
  output ctr_act_e act
);
  // Fixed priority: clear, then strobe, then step.
  always_comb begin
    if (!clr_n)       act = ACT_CLR;
    else if (!stb_n)  act = ACT_LOAD;
    else if (!step_n) act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  always_comb begin
    if (!clr_n) assert (act == ACT_CLR) else $error("p_clr_first_r6");
    if (clr_n && !stb_n) assert (act == ACT_LOAD) else $error("p_load_over_step_r4");
  end
endmodule

// File: rtl/burst_ctr_incr.sv
module burst_ctr_incr #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic          at_top
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  assign nxt    = cur + ONE;
  assign at_top = (cur == TOP);
endmodule

// File: rtl/burst_ctr_reg.sv
module burst_ctr_reg
  import burst_ctr_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  ctr_act_e      act,
  input  logic [AW-1:0] load_val,
  input  logic [AW-1:0] step_val,
  output logic [AW-1:0] q
);
  logic [AW-1:0] d;

  always_comb begin
    unique case (act)
      ACT_CLR:  d = '0;
      ACT_LOAD: d = load_val;
      ACT_STEP: d = step_val;
      default:  d = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_ctr_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          stb_n,
  input  logic          step_n,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  ctr_act_e      act;
  logic [AW-1:0] inc_val;
  logic          at_top;

  burst_ctr_decode u_dec (
    .clr_n  (clr_n),
    .stb_n  (stb_n),
    .step_n (step_n),
    .act    (act)
  );

  burst_ctr_incr #(.AW(AW)) u_inc (
    .cur    (addr_o),
    .nxt    (inc_val),
    .at_top (at_top)
  );

  burst_ctr_reg #(.AW(AW)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .load_val (addr_i),
    .step_val (inc_val),
    .q        (addr_o)
  );

  p_por_zero_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !stb_n) |=> (addr_o == $past(addr_i)));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && stb_n && !step_n) |=> (addr_o == $past(addr_o) + ONE));

  p_clr_beats_all_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |=> (addr_o == '0));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && stb_n && !step_n && at_top) |=> (addr_o == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_n && stb_n && step_n) |=> $stable(addr_o));
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 15;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_n = 1'b1;
  logic          stb_n = 1'b1;
  logic          step_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
    .clk(clk), .rst(rst), .clr_n(clr_n), .stb_n(stb_n),
    .step_n(step_n), .addr_i(addr_i), .addr_o(addr_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One cycle: drive on the falling edge, check shortly after the rising edge.
  task automatic step(input bit r, input bit c, input bit s, input bit e, input int a);
    string tag;
    @(negedge clk);
    rst = r; clr_n = c; stb_n = s; step_n = e; addr_i = AW'(a);
    if (r) begin model = 0; tag = "R1"; end
    else if (!c) begin model = 0; tag = (!s) ? "R6" : (!e ? "R5" : "R6"); end
    else if (!s) begin model = a & MASK; tag = (!e) ? "R4" : "R2"; end
    else if (!e) begin
      tag = (model == MASK) ? "R7" : "R3";
      model = (model + 1) & MASK;
    end
    else tag = "R8";
    @(posedge clk);
    #2;
    checks++;
    if (int'(addr_o) !== model) begin
      fails++;
      $display("FAIL %s: addr_o=%0h expected=%0h", tag, addr_o, model);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
    end
  end

  initial begin
    step(1, 0, 0, 0, 'h1234);             // R1 reset beats everything
    step(1, 1, 1, 1, 0);                  // R1
    step(0, 1, 0, 1, 'h0100);             // R2 load
    step(0, 1, 1, 0, 0);                  // R3 step
    step(0, 1, 1, 0, 0);                  // R3
    step(0, 1, 1, 1, 'h7777);             // R8 hold, addr_i ignored
    step(0, 1, 1, 1, 0);                  // R8
    step(0, 1, 0, 0, 'h2222);             // R4 strobe with step: no increment
    step(0, 1, 1, 1, 0);                  // R8
    step(0, 0, 1, 0, 0);                  // R5 clear with step
    step(0, 1, 0, 1, 'h0456);             // R2
    step(0, 0, 0, 1, 'h0999);             // R6 clear beats strobe
    step(0, 0, 0, 0, 'h0999);             // R6 all asserted
    step(0, 1, 0, 1, MASK - 1);           // R2 near top
    step(0, 1, 1, 0, 0);                  // R3 to all ones
    step(0, 1, 1, 0, 0);                  // R7 wrap
    step(0, 1, 1, 0, 0);                  // R3 after wrap
    step(0, 1, 0, 1, MASK);               // R2
    step(0, 1, 1, 0, 0);                  // R7
    step(0, 1, 1, 1, 0);                  // R8
    for (int i = 0; i < 400; i++) begin
      int ctl = $urandom_range(0, 15);
      step(ctl == 15, (ctl % 5) != 0, (ctl % 3) != 0, (ctl % 2) != 0,
           $urandom_range(0, MASK));
    end
    done = 1'b1;
    report();
  end
endmodule